// File: doc/BRIEF.md
# Boot Region Write Guard

This block sits between a flash command decoder and the array sequencer and decides which parts of the array a program or erase request may change. The array is split into four regions: an 8K-word boot region at the bottom of the word address space, two small parameter regions above it, and the main region that covers everything else. A sticky lockout flag shields the boot region. The command decoder sets the flag, and only a full power-up reset clears it. A high-voltage override input lets a single operation reach the boot region even while the flag is set.

The decoder presents one request at a time: a kind (program, sector erase or chip erase) and a word address. The guard answers one cycle later. It either grants the request and goes busy, or it rejects it with a one-cycle error pulse. While busy, it holds a per-region erase-enable vector or a program-allowed flag. The sequencer uses these as write gates until it reports completion. If the override drops while an operation that depends on it is still running, only the boot portion is withdrawn and an abort pulse is raised. In identification mode the guard also provides the lockout status bit for the read path.

Top module: `boot_guard`

## Requirements
- R1: Regions are decoded from the word address as follows: boot is 0x00000–0x01FFF, parameter A is 0x02000–0x02FFF, parameter B is 0x03000–0x03FFF, and main is 0x04000 and above. A granted sector erase drives `erase_en_o` bit 0, 1, 2 or 3 respectively.
- R2: After reset, `lock_o`, `busy_o`, `grant_o`, `reject_o`, `abort_o`, `prog_ok_o` and `erase_en_o` are all 0.
- R3: A cycle with `lock_set_i` high makes `lock_o` 1 from the next cycle on. `lock_o` then stays 1 until `rst_ni` is asserted, which is the only input that clears it.
- R4: While idle, a request (`req_kind_i` 2'b00 program, 2'b01 sector erase, 2'b10 chip erase) that is allowed produces a `grant_o` pulse one cycle later. `busy_o` goes high in that same cycle.
- R5: With the lock set and the override low, a program or sector erase aimed at the boot region produces a one-cycle `reject_o` pulse. It produces no grant, `busy_o` stays low and no enable is raised.
- R6: With the lock set, program and sector erase requests aimed at the parameter and main regions are still granted.
- R7: A chip erase enables all regions (`erase_en_o` = 4'b1111) when unlocked. When locked without override it enables only the non-boot regions (4'b1110).
- R8: If `hv_override_i` is high when a request is accepted, boot-region program, sector erase and chip erase are granted with the boot region enabled, even with the lock set.
- R9: If the override drops while an operation that reached the boot region only through the override is busy, then one cycle later the boot enable (`erase_en_o[0]`, or `prog_ok_o` for a boot program) is 0, `abort_o` pulses for one cycle, and the other regions stay enabled. Operations that do not depend on the override are unaffected. Once the override is removed, boot requests are rejected again.
- R10: While busy, requests produce neither grant nor reject and leave the enables unchanged. Kind code 2'b11 is ignored at all times. `op_done_i` ends the operation: one cycle later `busy_o`, `prog_ok_o` and `erase_en_o` are 0.
- R11: `id_bit_o` equals `lock_o` when `id_mode_i` is high and `rd_addr_i` is 0x00002. Otherwise it is 0.
- R12: During a granted program, `prog_ok_o` is 1 and `erase_en_o` is 0. During an erase, `prog_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low power-up reset, the only clear for the lock |
| lock_set_i | input | 1 | One-cycle pulse from the decoder: set the lockout flag |
| hv_override_i | input | 1 | High-voltage override level |
| req_valid_i | input | 1 | Request strobe |
| req_kind_i | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 ignored |
| req_addr_i | input | ADDR_W | Word address of the program target or erase sector |
| op_done_i | input | 1 | Sequencer reports the operation complete |
| id_mode_i | input | 1 | Identification-mode reads active |
| rd_addr_i | input | ADDR_W | Read word address |
| grant_o | output | 1 | One-cycle pulse: request accepted |
| reject_o | output | 1 | One-cycle pulse: request refused |
| abort_o | output | 1 | One-cycle pulse: boot work withdrawn after the override dropped |
| busy_o | output | 1 | Operation in progress |
| erase_en_o | output | 4 | Per-region erase gates (bit 0 boot, 1 param A, 2 param B, 3 main) |
| prog_ok_o | output | 1 | Program write gate for the current operation |
| lock_o | output | 1 | Lockout flag |
| id_bit_o | output | 1 | Lock status bit for identification reads |

## Verification
The bench probes region edges at 0x01FFF/0x02000, 0x02FFF/0x03000 and 0x03FFF/0x04000. An off-by-one in the decoder would enable a neighbouring region's erase gate. Chip erase under lock must still run with the boot bit clear; a design that rejected it, or erased everything, shows up in `erase_en_o`. The override is dropped partway through both a boot program and a chip erase, which catches a design that ignores the drop or kills the whole operation. It is also dropped during a main-region program, which catches a design that aborts unrelated work. Requests made while busy, and a reset that must clear the sticky lock, complete the set.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;

    localparam int N_REGIONS = 4;
    localparam int BOOT_IDX  = 0;

    typedef enum logic [1:0] {
        KIND_PROG  = 2'b00,
        KIND_SECT  = 2'b01,
        KIND_CHIP  = 2'b10,
        KIND_NONE  = 2'b11
    } req_kind_t;

    typedef struct packed {
        logic                 busy;
        logic                 grant;
        logic                 reject;
        logic                 abort;
        logic                 prog;
        logic                 ovr_dep;
        logic [N_REGIONS-1:0] en;
    } ctl_state_t;

    typedef struct packed {
        logic locked;
    } lock_state_t;

endpackage

// File: rtl/boot_guard_region.sv
module boot_guard_region
    import boot_guard_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int BOOT_WORDS  = 8192,
    parameter int PARAM_WORDS = 4096
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [N_REGIONS-1:0] hit_o
);

    localparam longint SPACE = longint'(1) << ADDR_W;

    logic [63:0] addr_w;
    assign addr_w = 64'(addr_i);

    for (genvar i = 0; i < N_REGIONS; i++) begin : g_reg
        localparam longint LO = (i == 0) ? 0 :
                                longint'(BOOT_WORDS) + longint'(i - 1) * longint'(PARAM_WORDS);
        localparam longint HI = (i == N_REGIONS - 1) ? SPACE :
                                longint'(BOOT_WORDS) + longint'(i) * longint'(PARAM_WORDS);
        if (i == 0) begin : g_first
            assign hit_o[i] = addr_w < 64'(HI);
        end else if (i == N_REGIONS - 1) begin : g_last
            assign hit_o[i] = addr_w >= 64'(LO);
        end else begin : g_mid
            assign hit_o[i] = (addr_w >= 64'(LO)) && (addr_w < 64'(HI));
        end
    end

endmodule

// File: rtl/boot_guard_lock.sv
module boot_guard_lock
    import boot_guard_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    output logic locked_o
);

    lock_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.locked = st_q.locked | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign locked_o = st_q.locked;

endmodule

// File: rtl/boot_guard_ctrl.sv
module boot_guard_ctrl
    import boot_guard_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_valid_i,
    input  req_kind_t            req_kind_i,
    input  logic [N_REGIONS-1:0] hit_i,
    input  logic                 locked_i,
    input  logic                 override_i,
    input  logic                 op_done_i,
    output logic                 grant_o,
    output logic                 reject_o,
    output logic                 abort_o,
    output logic                 busy_o,
    output logic [N_REGIONS-1:0] erase_en_o,
    output logic                 prog_ok_o
);

    localparam logic [N_REGIONS-1:0] ALL_REGIONS = '1;
    localparam logic [N_REGIONS-1:0] BOOT_MASK   = N_REGIONS'(1) << BOOT_IDX;

    ctl_state_t st_d, st_q;
    logic [N_REGIONS-1:0] target;
    logic [N_REGIONS-1:0] allowed;
    logic                 boot_ok;

    always_comb begin
        st_d        = st_q;
        st_d.grant  = 1'b0;
        st_d.reject = 1'b0;
        st_d.abort  = 1'b0;

        target  = (req_kind_i == KIND_CHIP) ? ALL_REGIONS : hit_i;
        boot_ok = !locked_i || override_i;
        allowed = boot_ok ? target : (target & ~BOOT_MASK);

        if (!st_q.busy) begin
            if (req_valid_i && req_kind_i != KIND_NONE) begin
                if (req_kind_i != KIND_CHIP && target[BOOT_IDX] && !boot_ok) begin
                    st_d.reject = 1'b1;
                end else begin
                    st_d.busy    = 1'b1;
                    st_d.grant   = 1'b1;
                    st_d.prog    = (req_kind_i == KIND_PROG);
                    st_d.en      = allowed;
                    st_d.ovr_dep = allowed[BOOT_IDX] && locked_i;
                end
            end
        end else if (op_done_i) begin
            st_d.busy    = 1'b0;
            st_d.prog    = 1'b0;
            st_d.ovr_dep = 1'b0;
            st_d.en      = '0;
        end else if (st_q.ovr_dep && !override_i) begin
            st_d.en[BOOT_IDX] = 1'b0;
            st_d.ovr_dep      = 1'b0;
            st_d.abort        = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign grant_o    = st_q.grant;
    assign reject_o   = st_q.reject;
    assign abort_o    = st_q.abort;
    assign busy_o     = st_q.busy;
    assign erase_en_o = st_q.prog ? '0 : st_q.en;
    assign prog_ok_o  = st_q.prog && (|st_q.en);

endmodule

// File: rtl/boot_guard.sv
module boot_guard
    import boot_guard_pkg::*;
#(
    parameter int ADDR_W       = 18,
    parameter int BOOT_WORDS   = 8192,
    parameter int PARAM_WORDS  = 4096,
    parameter int ID_LOCK_ADDR = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lock_set_i,
    input  logic              hv_override_i,
    input  logic              req_valid_i,
    input  logic [1:0]        req_kind_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              op_done_i,
    input  logic              id_mode_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              grant_o,
    output logic              reject_o,
    output logic              abort_o,
    output logic              busy_o,
    output logic [3:0]        erase_en_o,
    output logic              prog_ok_o,
    output logic              lock_o,
    output logic              id_bit_o
);

    localparam logic [ADDR_W-1:0] ID_ADDR = ADDR_W'(ID_LOCK_ADDR);

    logic [N_REGIONS-1:0] hit;
    logic                 locked;

    boot_guard_region #(
        .ADDR_W      (ADDR_W),
        .BOOT_WORDS  (BOOT_WORDS),
        .PARAM_WORDS (PARAM_WORDS)
    ) region_i (
        .addr_i (req_addr_i),
        .hit_o  (hit)
    );

    boot_guard_lock lock_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (lock_set_i),
        .locked_o (locked)
    );

    boot_guard_ctrl ctrl_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .req_kind_i  (req_kind_t'(req_kind_i)),
        .hit_i       (hit),
        .locked_i    (locked),
        .override_i  (hv_override_i),
        .op_done_i   (op_done_i),
        .grant_o     (grant_o),
        .reject_o    (reject_o),
        .abort_o     (abort_o),
        .busy_o      (busy_o),
        .erase_en_o  (erase_en_o),
        .prog_ok_o   (prog_ok_o)
    );

    assign lock_o   = locked;
    assign id_bit_o = id_mode_i && (rd_addr_i == ID_ADDR) && locked;

endmodule

// File: rtl/boot_guard_chk.sv
module boot_guard_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              lock_set_i,
    input logic              hv_override_i,
    input logic              req_valid_i,
    input logic [1:0]        req_kind_i,
    input logic              id_mode_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic              grant_o,
    input logic              reject_o,
    input logic              abort_o,
    input logic              busy_o,
    input logic [3:0]        erase_en_o,
    input logic              prog_ok_o,
    input logic              lock_o,
    input logic              id_bit_o
);

    // R3
    lock_set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_set_i |=> lock_o);

    // R3
    lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_o |=> lock_o);

    // R5
    reject_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reject_o |-> (!busy_o && !grant_o && erase_en_o == 4'b0000));

    // R4
    grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o |=> !grant_o);

    // R7
    chip_skip_boot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && !busy_o && req_kind_i == 2'b10 && lock_o && !hv_override_i)
        |=> (grant_o && erase_en_o == 4'b1110));

    // R10
    busy_ignores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o)) |-> (!grant_o && !reject_o));

    // R9
    abort_drops_boot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_o |-> (!erase_en_o[0] && !prog_ok_o && busy_o));

    // R12
    prog_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prog_ok_o |-> (erase_en_o == 4'b0000));

    // R11
    id_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_mode_i && rd_addr_i == ADDR_W'(2)) |-> (id_bit_o == lock_o));

endmodule

bind boot_guard boot_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lock_set_i    (lock_set_i),
    .hv_override_i (hv_override_i),
    .req_valid_i   (req_valid_i),
    .req_kind_i    (req_kind_i),
    .id_mode_i     (id_mode_i),
    .rd_addr_i     (rd_addr_i),
    .grant_o       (grant_o),
    .reject_o      (reject_o),
    .abort_o       (abort_o),
    .busy_o        (busy_o),
    .erase_en_o    (erase_en_o),
    .prog_ok_o     (prog_ok_o),
    .lock_o        (lock_o),
    .id_bit_o      (id_bit_o)
);

// File: tb/boot_guard_tb_top.sv
`timescale 1ns/1ps
module boot_guard_tb_top;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock_set = 1'b0;
    logic          ovr = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic          op_done = 1'b0;
    logic          id_mode = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          grant, reject, abort_p, busy, prog_ok, lock, id_bit;
    logic [3:0]    erase_en;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    boot_guard dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .lock_set_i    (lock_set),
        .hv_override_i (ovr),
        .req_valid_i   (req_valid),
        .req_kind_i    (req_kind),
        .req_addr_i    (req_addr),
        .op_done_i     (op_done),
        .id_mode_i     (id_mode),
        .rd_addr_i     (rd_addr),
        .grant_o       (grant),
        .reject_o      (reject),
        .abort_o       (abort_p),
        .busy_o        (busy),
        .erase_en_o    (erase_en),
        .prog_ok_o     (prog_ok),
        .lock_o        (lock),
        .id_bit_o      (id_bit)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one request for a single cycle; outputs are sampled afterwards
    task automatic issue(input logic [1:0] kind, input logic [AW-1:0] addr);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_op();
        @(negedge clk); op_done = 1'b1;
        @(negedge clk); op_done = 1'b0;
        chk(busy, 0, "R10 busy clears after done");
        chk(erase_en, 0, "R10 enables clear after done");
        chk(prog_ok, 0, "R10 prog_ok clears after done");
    endtask

    task automatic sect_region(input logic [AW-1:0] addr, input logic [3:0] exp, input string tag);
        issue(2'b01, addr);
        chk(grant, 1, tag);
        chk(erase_en, exp, tag);
        finish_op();
    endtask

    task automatic t_reset();
        chk(lock, 0, "R2 lock after reset");
        chk(busy, 0, "R2 busy after reset");
        chk({grant, reject, abort_p, prog_ok}, 0, "R2 pulses after reset");
        chk(erase_en, 0, "R2 enables after reset");
        id_mode = 1'b1; rd_addr = AW'(2); #1;
        chk(id_bit, 0, "R11 id bit unlocked");
        id_mode = 1'b0;
    endtask

    task automatic t_unlocked();
        issue(2'b00, AW'('h1FFF));
        chk(grant, 1, "R4 program grant");
        chk(busy, 1, "R4 busy with grant");
        chk(prog_ok, 1, "R12 prog_ok during program");
        chk(erase_en, 0, "R12 no erase during program");
        @(negedge clk);
        chk(grant, 0, "R4 grant is one cycle");
        finish_op();
        sect_region(AW'('h0000),  4'b0001, "R1 boot low");
        sect_region(AW'('h1FFF),  4'b0001, "R1 boot top");
        sect_region(AW'('h2000),  4'b0010, "R1 param A low");
        sect_region(AW'('h2FFF),  4'b0010, "R1 param A top");
        sect_region(AW'('h3000),  4'b0100, "R1 param B low");
        sect_region(AW'('h3FFF),  4'b0100, "R1 param B top");
        sect_region(AW'('h4000),  4'b1000, "R1 main low");
        sect_region(AW'('h3FFFF), 4'b1000, "R1 main top");
        issue(2'b01, AW'('h2000));
        chk(prog_ok, 0, "R12 prog_ok low during erase");
        finish_op();
        issue(2'b10, AW'(0));
        chk(erase_en, 4'b1111, "R7 chip erase unlocked");
        finish_op();
    endtask

    task automatic t_lock();
        @(negedge clk); lock_set = 1'b1;
        @(negedge clk); lock_set = 1'b0;
        chk(lock, 1, "R3 lock set");
        repeat (3) @(negedge clk);
        chk(lock, 1, "R3 lock sticky");
        id_mode = 1'b1; rd_addr = AW'(2); #1;
        chk(id_bit, 1, "R11 id bit locked");
        rd_addr = AW'(3); #1;
        chk(id_bit, 0, "R11 other address");
        rd_addr = AW'(2); id_mode = 1'b0; #1;
        chk(id_bit, 0, "R11 outside id mode");
    endtask

    task automatic t_locked_reject();
        issue(2'b00, AW'('h0100));
        chk(reject, 1, "R5 program boot rejected");
        chk(grant, 0, "R5 no grant");
        chk(busy, 0, "R5 not busy");
        @(negedge clk);
        chk(reject, 0, "R5 reject one cycle");
        issue(2'b01, AW'('h1FFF));
        chk(reject, 1, "R5 sector boot rejected");
        chk(erase_en, 0, "R5 no enables");
        issue(2'b00, AW'('h2000));
        chk(grant, 1, "R6 program param A granted");
        chk(prog_ok, 1, "R6 prog_ok param A");
        finish_op();
        issue(2'b01, AW'('h4000));
        chk(erase_en, 4'b1000, "R6 sector main granted");
        finish_op();
        issue(2'b10, AW'(0));
        chk(grant, 1, "R7 locked chip granted");
        chk(erase_en, 4'b1110, "R7 locked chip skips boot");
        finish_op();
    endtask

    task automatic t_busy_ignore();
        issue(2'b11, AW'('h5000));
        chk({grant, reject, busy}, 0, "R10 kind 11 ignored");
        issue(2'b00, AW'('h5000));
        chk(grant, 1, "R4 program main");
        issue(2'b01, AW'('h0000));
        chk({grant, reject}, 0, "R10 request while busy ignored");
        chk(erase_en, 0, "R10 enables unchanged");
        chk(prog_ok, 1, "R10 prog_ok unchanged");
        finish_op();
    endtask

    task automatic t_override();
        ovr = 1'b1;
        issue(2'b00, AW'('h0010));
        chk(grant, 1, "R8 override program boot");
        chk(prog_ok, 1, "R8 prog_ok boot");
        finish_op();
        issue(2'b10, AW'(0));
        chk(erase_en, 4'b1111, "R8 override chip all regions");
        @(negedge clk); ovr = 1'b0;
        @(negedge clk);
        chk(erase_en, 4'b1110, "R9 boot withdrawn");
        chk(abort_p, 1, "R9 abort pulse");
        chk(busy, 1, "R9 still busy");
        @(negedge clk);
        chk(abort_p, 0, "R9 abort one cycle");
        finish_op();
        issue(2'b01, AW'('h0000));
        chk(reject, 1, "R9 lock back after override");
        ovr = 1'b1;
        issue(2'b00, AW'('h0020));
        chk(prog_ok, 1, "R8 override program");
        @(negedge clk); ovr = 1'b0;
        @(negedge clk);
        chk(prog_ok, 0, "R9 boot program withdrawn");
        chk(abort_p, 1, "R9 abort on program");
        finish_op();
        ovr = 1'b1;
        issue(2'b00, AW'('h8000));
        @(negedge clk); ovr = 1'b0;
        @(negedge clk);
        chk(abort_p, 0, "R9 main program not aborted");
        chk(prog_ok, 1, "R9 main program continues");
        finish_op();
    endtask

    task automatic t_reset_clear();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(lock, 0, "R3 reset clears lock");
        issue(2'b01, AW'('h0000));
        chk(grant, 1, "R3 boot erasable after reset");
        finish_op();
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unlocked();
        t_lock();
        t_locked_reject();
        t_busy_ignore();
        t_override();
        t_reset_clear();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule